// File: doc/BRIEF.md
# Core Clock Strobe Divider

This block turns one reference clock into three clock-enable strobes: one for the processor, one for the system bus and one for the peripheral bus. Each strobe is high for a single reference cycle once per divided period. Logic in each downstream domain stays on the reference clock and acts only in cycles where its strobe is high. This avoids gated or derived clocks.

A 32-bit configuration word holds all three divisors. The processor and system-bus divisors come from fixed tables, and the bus table has the non-binary values 5 and 6. The peripheral divisor counts system-bus strobes, not reference cycles, so its period is the product of the two divisors. One bit of the word selects how the counters advance. They can advance on every reference cycle, which is the PLL path. They can also advance only on cycles marked by a slower crystal tick, which is the bypass path.

A divisor change is held back until the affected counter reaches its terminal count, so no period is ever cut short. A status output reports when all three running divisors match the current word.

Top module: `core_strobe_div`

## Requirements
- R1: The processor divisor is set by cfg_word[27:25]: codes 0,1,2,3,4 give 1,2,4,8,16, and codes 5,6,7 give 1.
- R2: The system-bus divisor is set by cfg_word[22:20]: codes 0..7 give 1,2,4,5,6,8,16,32.
- R3: The peripheral divisor is set by cfg_word[19:18] (codes 0..3 give 1,2,4,8). It counts system-bus strobes, and per_stb is never high in a cycle where bus_stb is low.
- R4: When cfg_word[23] is 1, every reference cycle is counted. When it is 0, only cycles with xtal_tick high are counted, and processor and bus strobes appear only in such cycles.
- R5: A divisor of 1 gives a strobe in every counted cycle.
- R6: While rst is high, all strobes are low. After release, a unit with divisor N first strobes on its Nth counted cycle, and then strobes every N counted cycles.
- R7: A divisor change takes effect only after the current period ends at the old terminal count. The period in progress keeps its old length.
- R8: cfg_applied is high exactly when all three running divisors equal those requested by cfg_word. It can rise only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Divisor and source-select configuration |
| xtal_tick | input | 1 | Count qualifier used when cfg_word[23] is 0 |
| cpu_stb | output | 1 | Processor clock-enable strobe |
| bus_stb | output | 1 | System-bus clock-enable strobe |
| per_stb | output | 1 | Peripheral-bus clock-enable strobe |
| cfg_applied | output | 1 | All running divisors match cfg_word |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a period. Only then do the pending and running divisors differ, so only then can a shortened period or an early cfg_applied appear. The stimulus first resets into a long divisor. It then rewrites the word a few counted cycles in and checks the exact cycle of each following strobe, together with the cycle in which cfg_applied goes high again. A full sweep of all 256 divisor-code combinations, each started from reset, checks the first-strobe position and the period of the cascaded peripheral strobe for every product of the two divisors.

// File: rtl/strobe_div_pkg.sv
package strobe_div_pkg;
    localparam int CFG_W   = 32;
    localparam int CPU_LSB = 25;
    localparam int BUS_LSB = 20;
    localparam int PER_LSB = 18;
    localparam int SRC_BIT = 23;
    localparam int DIV_W   = 6;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        div_t cpu;
        div_t bus;
        div_t per;
        logic src_pll;
    } div_cfg_t;

    function automatic div_t cpu_div_of(input logic [2:0] code);
        case (code)
            3'd1:    return div_t'(2);
            3'd2:    return div_t'(4);
            3'd3:    return div_t'(8);
            3'd4:    return div_t'(16);
            default: return div_t'(1);
        endcase
    endfunction

    function automatic div_t bus_div_of(input logic [2:0] code);
        case (code)
            3'd0:    return div_t'(1);
            3'd1:    return div_t'(2);
            3'd2:    return div_t'(4);
            3'd3:    return div_t'(5);
            3'd4:    return div_t'(6);
            3'd5:    return div_t'(8);
            3'd6:    return div_t'(16);
            default: return div_t'(32);
        endcase
    endfunction

    function automatic div_t per_div_of(input logic [1:0] code);
        return div_t'(1) << code;
    endfunction
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import strobe_div_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output div_cfg_t         cfg
);
    always_comb begin
        cfg.cpu     = cpu_div_of(cfg_word[CPU_LSB +: 3]);
        cfg.bus     = bus_div_of(cfg_word[BUS_LSB +: 3]);
        cfg.per     = per_div_of(cfg_word[PER_LSB +: 2]);
        cfg.src_pll = cfg_word[SRC_BIT];
    end
endmodule

// File: rtl/div_unit.sv
module div_unit #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] div_req,
    output logic         stb,
    output logic [W-1:0] div_cur
);
    logic [W-1:0] cnt;
    logic         terminal;

    assign terminal = (cnt == div_cur - W'(1));
    assign stb      = !rst && adv && terminal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_cur <= div_req;
        end else if (adv) begin
            if (terminal) begin
                cnt     <= '0;
                div_cur <= div_req;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/core_strobe_div.sv
module core_strobe_div
    import strobe_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             xtal_tick,
    output logic             cpu_stb,
    output logic             bus_stb,
    output logic             per_stb,
    output logic             cfg_applied
);
    div_cfg_t req;
    logic     src_adv;
    div_t     cpu_run, bus_run, per_run;

    cfg_decode u_dec (.cfg_word(cfg_word), .cfg(req));

    assign src_adv = req.src_pll | xtal_tick;

    div_unit #(.W(DIV_W)) u_cpu (
        .clk(clk), .rst(rst), .adv(src_adv), .div_req(req.cpu),
        .stb(cpu_stb), .div_cur(cpu_run)
    );

    div_unit #(.W(DIV_W)) u_bus (
        .clk(clk), .rst(rst), .adv(src_adv), .div_req(req.bus),
        .stb(bus_stb), .div_cur(bus_run)
    );

    div_unit #(.W(DIV_W)) u_per (
        .clk(clk), .rst(rst), .adv(bus_stb), .div_req(req.per),
        .stb(per_stb), .div_cur(per_run)
    );

    assign cfg_applied = (cpu_run == req.cpu) && (bus_run == req.bus) &&
                         (per_run == req.per);
endmodule

// File: rtl/core_strobe_div_chk.sv
module core_strobe_div_chk
    import strobe_div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_word,
    input logic             xtal_tick,
    input logic             cpu_stb,
    input logic             bus_stb,
    input logic             per_stb,
    input logic             cfg_applied
);
    logic counted;
    logic cpu_is_one;
    assign counted    = cfg_word[SRC_BIT] | xtal_tick;
    assign cpu_is_one = (cfg_word[CPU_LSB +: 3] == 3'd0) || (cfg_word[CPU_LSB +: 3] > 3'd4);

    assert_per_in_bus_R3: assert property (@(posedge clk) disable iff (rst)
        per_stb |-> bus_stb);

    assert_uncounted_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !counted |-> (!cpu_stb && !bus_stb));

    assert_div_one_every_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_applied && cpu_is_one && counted) |-> cpu_stb);

    assert_applied_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_applied && !cpu_stb && !bus_stb && !per_stb) |=>
            (!cfg_applied || !$stable(cfg_word)));

    always_comb begin
        if (rst) begin
            assert_reset_quiet_R6: assert (!cpu_stb && !bus_stb && !per_stb);
        end
    end
endmodule

bind core_strobe_div core_strobe_div_chk u_chk (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .xtal_tick(xtal_tick),
    .cpu_stb(cpu_stb), .bus_stb(bus_stb), .per_stb(per_stb),
    .cfg_applied(cfg_applied)
);

// File: tb/core_strobe_div_bench.sv
module core_strobe_div_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        xtal_tick = 1'b0;
    logic        cpu_stb, bus_stb, per_stb, cfg_applied;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_strobe_div u_core_strobe_div (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .xtal_tick(xtal_tick),
        .cpu_stb(cpu_stb), .bus_stb(bus_stb), .per_stb(per_stb),
        .cfg_applied(cfg_applied)
    );

    function automatic logic [31:0] mk(input int c, input int b, input int p, input bit src);
        logic [31:0] w = '0;
        w[27:25] = 3'(c);
        w[22:20] = 3'(b);
        w[19:18] = 2'(p);
        w[23]    = src;
        return w;
    endfunction

    function automatic int cpu_n(input int c);
        return (c < 5) ? (1 << c) : 1;
    endfunction

    function automatic int bus_n(input int b);
        if (b < 3) return 1 << b;
        if (b < 5) return b + 2;
        return 1 << (b - 2);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [31:0] w);
        cfg_word  = w;
        rst       = 1'b1;
        xtal_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R6 strobes in reset", int'({cpu_stb, bus_stb, per_stb}), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 8; b++) begin
                for (int p = 0; p < 4; p++) begin
                    int nc, nb, np, lim;
                    int fc, sc, fb, sb, fp, sp, viol, lows;
                    nc = cpu_n(c); nb = bus_n(b); np = nb * (1 << p);
                    lim = 2 * ((nc > np) ? nc : np);
                    fc = 0; sc = 0; fb = 0; sb = 0; fp = 0; sp = 0; viol = 0; lows = 0;
                    do_reset(mk(c, b, p, 1'b1));
                    for (int k = 1; k <= lim; k++) begin
                        if (cpu_stb) begin if (fc == 0) fc = k; else if (sc == 0) sc = k; end
                        if (bus_stb) begin if (fb == 0) fb = k; else if (sb == 0) sb = k; end
                        if (per_stb) begin if (fp == 0) fp = k; else if (sp == 0) sp = k; end
                        if (per_stb && !bus_stb) viol++;
                        if (!cfg_applied) lows++;
                        step();
                    end
                    chk("R1 R6 cpu first strobe", fc, nc);
                    chk("R1 cpu period", sc - fc, nc);
                    chk("R2 R6 bus first strobe", fb, nb);
                    chk("R2 bus period", sb - fb, nb);
                    chk("R3 per first strobe", fp, np);
                    chk("R3 per period", sp - fp, np);
                    chk("R3 per without bus", viol, 0);
                    chk("R8 applied held", lows, 0);
                end
            end
        end

        // R4 and R5: crystal qualifier, cpu divide-by-1, bus divide-by-2
        do_reset(mk(0, 1, 0, 1'b0));
        begin
            int cm, bm;
            cm = 0; bm = 0;
            for (int k = 1; k <= 30; k++) begin
                xtal_tick = (k % 3 == 0);
                #1;
                if (cpu_stb != xtal_tick) cm++;
                if (bus_stb != (k % 6 == 0)) bm++;
                step();
            end
            xtal_tick = 1'b0;
            chk("R4 R5 cpu follows tick", cm, 0);
            chk("R4 bus every second tick", bm, 0);
        end

        // R7 and R8: bus divisor 5 changed to 2 mid-period
        do_reset(mk(0, 3, 0, 1'b1));
        begin
            int bmask, amask;
            bmask = 0; amask = 0;
            for (int k = 1; k <= 9; k++) begin
                if (bus_stb) bmask |= (1 << k);
                if (cfg_applied) amask |= (1 << k);
                if (k == 2) cfg_word = mk(0, 1, 0, 1'b1);
                step();
            end
            chk("R7 bus strobe cycles", bmask, (1 << 5) | (1 << 7) | (1 << 9));
            chk("R8 applied cycles", amask, (1 << 1) | (1 << 2) | (1 << 6) | (1 << 7) | (1 << 8) | (1 << 9));
        end

        // R7: cpu divisor 16 changed to 1 mid-period
        do_reset(mk(4, 0, 0, 1'b1));
        begin
            int first, cnt;
            first = 0; cnt = 0;
            for (int k = 1; k <= 18; k++) begin
                if (cpu_stb) begin cnt++; if (first == 0) first = k; end
                if (k == 3) cfg_word = mk(0, 0, 0, 1'b1);
                step();
            end
            chk("R7 cpu old period kept", first, 16);
            chk("R7 cpu strobes after change", cnt, 3);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule